// File: doc/BRIEF.md
# AUX Request Command Queue Engine

The engine accepts one AUX channel request at a time from a host port and converts it into a stream of words for a byte-wide command FIFO. A request names a 20-bit target address, a direction, whether it is a native or an I2C-over-AUX access, a byte count from 1 to 255, and two I2C framing options (suppress the address phase, suppress the stop condition). The engine builds a four-byte header from these fields and pushes it. For writes it then pushes the payload, which it fetches from the host one byte per cycle through an index port. Last, it writes a transaction-control word that starts the transfer.

The engine stays busy until the link side reports completion or an error. On a completed read it drains the reply. It first issues one command word that rewinds the FIFO index and selects read-out. It then pops and drops the first returned entry. Each later entry gives one data byte and an index tag, and the byte goes to the reply buffer only while the tag matches the running count. The first mismatch ends the unload early. A single response pulse reports a status code and the number of bytes handled.

Top module: `auxq_engine`

## Requirements
- R1: Header byte 0 carries address bits 19:16 in bits 3:0 and sets bit 4 for a read. Header byte 1 is address bits 15:8 and header byte 2 is address bits 7:0. The header is pushed in the order byte 0, 1, 2, 3.
- R2: Header byte 3 equals the request length minus one.
- R3: A write pushes its payload bytes in index order right after the header. A read pushes the four header bytes only.
- R4: A write longer than 124 bytes is refused. Nothing is pushed, no control word is issued, and the response has status 1 with count 0. A write of exactly 124 bytes is accepted and pushes 128 words.
- R5: In every FIFO word the byte sits in bits 15:8. Each header and payload word sets the write strobe in bit 24. Only the first word of a request sets the index-reset flag in bit 31.
- R6: The 4-bit control word always sets go (bit 0). For an I2C request it sets bit 1, and it sets bit 2 (no address phase) and bit 3 (no stop) when those options are requested. For a native request bits 3:1 are zero whatever options are given.
- R7: `busy` rises in the cycle after a request is taken and falls in the cycle after the response pulse. A request presented while busy is ignored.
- R8: An error indication while waiting ends the request with status 2 and count 0, and no read-out takes place. If error and completion arrive in the same cycle, the error wins.
- R9: After a read completes, the engine writes one FIFO word with bits 31 and 25 set and the strobe clear. It then pops one entry and discards it.
- R10: Each later popped entry is compared by its index tag in bits 23:16 against the running count from 0. A match writes bits 15:8 to the reply buffer at that count. A mismatch stops the unload, and the count of matched bytes is reported.
- R11: A successful request responds with status 0. The count is the length for a write, and for a read that unloads fully it is also the length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present (taken only when idle) |
| req_read | input | 1 | 1 = read, 0 = write |
| req_native | input | 1 | 1 = native access, 0 = I2C over AUX |
| req_no_addr | input | 1 | I2C: suppress address phase |
| req_no_stop | input | 1 | I2C: suppress stop condition |
| req_addr | input | 20 | Target address |
| req_len | input | 8 | Byte count, 1 to 255 |
| pay_idx | output | 8 | Index of the payload byte wanted this cycle |
| pay_byte | input | 8 | Payload byte at `pay_idx` |
| fifo_wr_en | output | 1 | Command FIFO write |
| fifo_wr_word | output | 32 | Command FIFO word |
| ctrl_wr_en | output | 1 | Transaction-control write |
| ctrl_word | output | 4 | Transaction-control value |
| done_in | input | 1 | Link reports transfer complete |
| err_in | input | 1 | Link reports transfer failure |
| fifo_rd_en | output | 1 | Pop reply FIFO entry |
| fifo_rd_word | input | 32 | Reply FIFO head entry |
| reply_we | output | 1 | Reply buffer write |
| reply_idx | output | 8 | Reply buffer address |
| reply_byte | output | 8 | Reply buffer data |
| busy | output | 1 | Request in progress |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_status | output | 2 | 0 ok, 1 refused, 2 link error |
| resp_count | output | 8 | Bytes handled |

## Verification
Completion and error can both be signalled in the same waiting cycle. When that happens, the error has to be taken and the read-out has to be skipped. The bench provokes this by raising `done_in` and `err_in` together on a pending read. It then judges the result at the ports: status 2, no read-out command word, no reply FIFO pop and no reply buffer write. A second overlap, a new request arriving while one is outstanding, is checked through the FIFO word count and the response count.

// File: rtl/auxq_pkg.sv
package auxq_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_PUSH, S_CTRL, S_WAIT, S_RDCMD, S_DROP, S_UNLOAD, S_RESP
   } auxq_state_e;

   localparam logic [1:0] ST_OK     = 2'd0;
   localparam logic [1:0] ST_REFUSE = 2'd1;
   localparam logic [1:0] ST_LINK   = 2'd2;

   localparam int W_BYTE_LSB = 8;
   localparam int W_TAG_LSB  = 16;
   localparam int W_STROBE   = 24;
   localparam int W_RDSEL    = 25;
   localparam int W_IRESET   = 31;

   localparam int HDR_BYTES = 4;
endpackage

// File: rtl/auxq_hdr_pack.sv
module auxq_hdr_pack #(
   parameter int ADDR_W = 20,
   parameter int LEN_W  = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic [LEN_W-1:0]  len,
   input  logic [1:0]        sel,
   output logic [7:0]        hdr_byte
);
   logic [7:0] len_m1;
   assign len_m1 = 8'(len) - 8'd1;

   always_comb begin
      unique case (sel)
         2'd0:    hdr_byte = {3'b000, rd, addr[19:16]};
         2'd1:    hdr_byte = addr[15:8];
         2'd2:    hdr_byte = addr[7:0];
         default: hdr_byte = len_m1;
      endcase
   end
endmodule

// File: rtl/auxq_word_fmt.sv
module auxq_word_fmt
   import auxq_pkg::*;
(
   input  logic [7:0]  data,
   input  logic        ireset,
   input  logic        strobe,
   input  logic        rdsel,
   output logic [31:0] word
);
   always_comb begin
      word = '0;
      word[W_BYTE_LSB +: 8] = data;
      word[W_STROBE]        = strobe;
      word[W_RDSEL]         = rdsel;
      word[W_IRESET]        = ireset;
   end
endmodule

// File: rtl/auxq_tag_check.sv
module auxq_tag_check
   import auxq_pkg::*;
#(
   parameter int LEN_W       = 8,
   parameter bit CHECK_INDEX = 1'b1
) (
   input  logic [31:0]      entry,
   input  logic [LEN_W-1:0] expect_idx,
   output logic             match,
   output logic [7:0]       data
);
   assign data = entry[W_BYTE_LSB +: 8];

   generate
      if (CHECK_INDEX) begin : g_strict
         assign match = (entry[W_TAG_LSB +: 8] == 8'(expect_idx));
      end else begin : g_trust
         assign match = 1'b1;
      end
   endgenerate

   logic unused_bits;
   assign unused_bits = ^{entry[7:0], entry[31:24], expect_idx};
endmodule

// File: rtl/auxq_engine.sv
module auxq_engine
   import auxq_pkg::*;
#(
   parameter int ADDR_W      = 20,
   parameter int LEN_W       = 8,
   parameter int FIFO_BUDGET = 128,
   parameter bit CHECK_INDEX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_read,
   input  logic              req_native,
   input  logic              req_no_addr,
   input  logic              req_no_stop,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   output logic [LEN_W-1:0]  pay_idx,
   input  logic [7:0]        pay_byte,
   output logic              fifo_wr_en,
   output logic [31:0]       fifo_wr_word,
   output logic              ctrl_wr_en,
   output logic [3:0]        ctrl_word,
   input  logic              done_in,
   input  logic              err_in,
   output logic              fifo_rd_en,
   input  logic [31:0]       fifo_rd_word,
   output logic              reply_we,
   output logic [LEN_W-1:0]  reply_idx,
   output logic [7:0]        reply_byte,
   output logic              busy,
   output logic              resp_valid,
   output logic [1:0]        resp_status,
   output logic [LEN_W-1:0]  resp_count
);
   localparam int CNT_W  = LEN_W + 2;
   localparam int MAX_WR = FIFO_BUDGET - HDR_BYTES;

   generate
      if (ADDR_W != 20) begin : g_bad_addr
         $error("auxq_engine: header layout needs a 20-bit address");
      end
      if (LEN_W > 8 || LEN_W < 1) begin : g_bad_len
         $error("auxq_engine: length must fit one header byte");
      end
      if (FIFO_BUDGET <= HDR_BYTES) begin : g_bad_budget
         $error("auxq_engine: FIFO budget must exceed header size");
      end
   endgenerate

   auxq_state_e       st_q;
   logic              rd_q, nat_q, noaddr_q, nostop_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  len_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [1:0]        status_q;
   logic [LEN_W-1:0]  count_q;

   logic [CNT_W-1:0]  push_total;
   logic [CNT_W-1:0]  pay_off;
   logic [7:0]        hdr_byte, push_byte;
   logic              tag_ok;
   logic [7:0]        tag_data;
   logic              refuse;

   assign push_total = rd_q ? CNT_W'(HDR_BYTES) : CNT_W'(HDR_BYTES) + CNT_W'(len_q);
   assign pay_off    = cnt_q - CNT_W'(HDR_BYTES);
   assign pay_idx    = pay_off[LEN_W-1:0];
   assign refuse     = !req_read && (CNT_W'(req_len) > CNT_W'(MAX_WR));

   auxq_hdr_pack #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_hdr (
      .addr(addr_q), .rd(rd_q), .len(len_q), .sel(cnt_q[1:0]), .hdr_byte(hdr_byte)
   );

   assign push_byte = (cnt_q < CNT_W'(HDR_BYTES)) ? hdr_byte : pay_byte;

   auxq_word_fmt u_fmt (
      .data   ((st_q == S_PUSH) ? push_byte : 8'h00),
      .ireset ((st_q == S_RDCMD) || (cnt_q == '0)),
      .strobe (st_q == S_PUSH),
      .rdsel  (st_q == S_RDCMD),
      .word   (fifo_wr_word)
   );

   auxq_tag_check #(.LEN_W(LEN_W), .CHECK_INDEX(CHECK_INDEX)) u_tag (
      .entry(fifo_rd_word), .expect_idx(cnt_q[LEN_W-1:0]), .match(tag_ok), .data(tag_data)
   );

   assign fifo_wr_en  = (st_q == S_PUSH) || (st_q == S_RDCMD);
   assign ctrl_wr_en  = (st_q == S_CTRL);
   assign ctrl_word   = {nostop_q & ~nat_q, noaddr_q & ~nat_q, ~nat_q, 1'b1};
   assign fifo_rd_en  = (st_q == S_DROP) || (st_q == S_UNLOAD);
   assign reply_we    = (st_q == S_UNLOAD) && tag_ok;
   assign reply_idx   = cnt_q[LEN_W-1:0];
   assign reply_byte  = tag_data;
   assign busy        = (st_q != S_IDLE);
   assign resp_valid  = (st_q == S_RESP);
   assign resp_status = status_q;
   assign resp_count  = count_q;

   logic unused_hi;
   assign unused_hi = ^pay_off[CNT_W-1:LEN_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= S_IDLE;
         rd_q     <= 1'b0;
         nat_q    <= 1'b0;
         noaddr_q <= 1'b0;
         nostop_q <= 1'b0;
         addr_q   <= '0;
         len_q    <= '0;
         cnt_q    <= '0;
         status_q <= ST_OK;
         count_q  <= '0;
      end else begin
         unique case (st_q)
            S_IDLE: if (req_valid) begin
               rd_q     <= req_read;
               nat_q    <= req_native;
               noaddr_q <= req_no_addr;
               nostop_q <= req_no_stop;
               addr_q   <= req_addr;
               len_q    <= req_len;
               cnt_q    <= '0;
               if (refuse) begin
                  status_q <= ST_REFUSE;
                  count_q  <= '0;
                  st_q     <= S_RESP;
               end else begin
                  st_q <= S_PUSH;
               end
            end
            S_PUSH: if (cnt_q == push_total - 1'b1) begin
               cnt_q <= '0;
               st_q  <= S_CTRL;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
            S_CTRL: st_q <= S_WAIT;
            S_WAIT: if (err_in) begin
               status_q <= ST_LINK;
               count_q  <= '0;
               st_q     <= S_RESP;
            end else if (done_in) begin
               if (rd_q) begin
                  st_q <= S_RDCMD;
               end else begin
                  status_q <= ST_OK;
                  count_q  <= len_q;
                  st_q     <= S_RESP;
               end
            end
            S_RDCMD: st_q <= S_DROP;
            S_DROP: begin
               cnt_q <= '0;
               st_q  <= S_UNLOAD;
            end
            S_UNLOAD: if (!tag_ok) begin
               status_q <= ST_OK;
               count_q  <= cnt_q[LEN_W-1:0];
               st_q     <= S_RESP;
            end else if (cnt_q + 1'b1 == CNT_W'(len_q)) begin
               status_q <= ST_OK;
               count_q  <= len_q;
               st_q     <= S_RESP;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/auxq_engine_chk.sv
module auxq_engine_chk #(
   parameter int LEN_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             fifo_wr_en,
   input logic [31:0]      fifo_wr_word,
   input logic             ctrl_wr_en,
   input logic             fifo_rd_en,
   input logic [31:0]      fifo_rd_word,
   input logic             reply_we,
   input logic [LEN_W-1:0] reply_idx,
   input logic             resp_valid,
   input logic [1:0]       resp_status
);
   logic pushed_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pushed_q <= 1'b0;
      else if (!busy)      pushed_q <= 1'b0;
      else if (fifo_wr_en) pushed_q <= 1'b1;
   end

   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !fifo_wr_en && !ctrl_wr_en && !fifo_rd_en && !reply_we);

   p_resp_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !busy);

   p_refuse_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_status == 2'd1) |-> !pushed_q);

   p_ireset_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr_en && fifo_wr_word[24]) |-> (fifo_wr_word[31] == !pushed_q));

   p_reply_tag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reply_we |-> (fifo_rd_word[23:16] == 8'(reply_idx)));

   p_go_then_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr_en |=> busy && !fifo_wr_en && !ctrl_wr_en);
endmodule

bind auxq_engine auxq_engine_chk #(.LEN_W(LEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .fifo_wr_en(fifo_wr_en),
   .fifo_wr_word(fifo_wr_word), .ctrl_wr_en(ctrl_wr_en), .fifo_rd_en(fifo_rd_en),
   .fifo_rd_word(fifo_rd_word), .reply_we(reply_we), .reply_idx(reply_idx),
   .resp_valid(resp_valid), .resp_status(resp_status)
);

// File: tb/auxq_engine_bench.sv
module auxq_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_read = 1'b0, req_native = 1'b0;
   logic        req_no_addr = 1'b0, req_no_stop = 1'b0;
   logic [19:0] req_addr = '0;
   logic [7:0]  req_len = '0;
   logic [7:0]  pay_idx, pay_byte;
   logic        fifo_wr_en, ctrl_wr_en, fifo_rd_en, reply_we, busy, resp_valid;
   logic [31:0] fifo_wr_word, fifo_rd_word;
   logic [3:0]  ctrl_word;
   logic        done_in = 1'b0, err_in = 1'b0;
   logic [7:0]  reply_idx, reply_byte, resp_count;
   logic [1:0]  resp_status;

   always #10 clk = ~clk;

   logic [7:0]  payload [0:255];
   logic [31:0] rsp_mem [0:15];
   int          rptr = 0;
   assign pay_byte     = payload[pay_idx];
   assign fifo_rd_word = rsp_mem[rptr[3:0]];
   always @(posedge clk) if (fifo_rd_en) rptr <= rptr + 1;

   auxq_engine u_auxq_engine (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
      .req_native(req_native), .req_no_addr(req_no_addr), .req_no_stop(req_no_stop),
      .req_addr(req_addr), .req_len(req_len), .pay_idx(pay_idx), .pay_byte(pay_byte),
      .fifo_wr_en(fifo_wr_en), .fifo_wr_word(fifo_wr_word), .ctrl_wr_en(ctrl_wr_en),
      .ctrl_word(ctrl_word), .done_in(done_in), .err_in(err_in), .fifo_rd_en(fifo_rd_en),
      .fifo_rd_word(fifo_rd_word), .reply_we(reply_we), .reply_idx(reply_idx),
      .reply_byte(reply_byte), .busy(busy), .resp_valid(resp_valid),
      .resp_status(resp_status), .resp_count(resp_count)
   );

   logic [31:0] wlog [0:1023];
   logic [3:0]  clog [0:63];
   logic [7:0]  rlog_b [0:255];
   logic [7:0]  rlog_i [0:255];
   int wn = 0, cn = 0, rn = 0, rsn = 0;
   logic [1:0]  rs_stat;
   logic [7:0]  rs_cnt;

   always @(negedge clk) begin
      if (fifo_wr_en) begin wlog[wn % 1024] <= fifo_wr_word; wn <= wn + 1; end
      if (ctrl_wr_en) begin clog[cn % 64] <= ctrl_word; cn <= cn + 1; end
      if (reply_we) begin
         rlog_b[rn % 256] <= reply_byte; rlog_i[rn % 256] <= reply_idx; rn <= rn + 1;
      end
      if (resp_valid) begin rs_stat <= resp_status; rs_cnt <= resp_count; rsn <= rsn + 1; end
   end

   int n_run = 0, n_fail = 0;
   bit finished = 1'b0;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] xw(input logic [7:0] b, input bit ir, input bit stb, input bit rs);
      logic [31:0] w;
      w = '0; w[15:8] = b; w[24] = stb; w[25] = rs; w[31] = ir;
      return w;
   endfunction

   task automatic send(input bit rd, input bit nat, input bit na, input bit ns,
                       input logic [19:0] a, input logic [7:0] l);
      @(negedge clk);
      req_valid = 1'b1; req_read = rd; req_native = nat;
      req_no_addr = na; req_no_stop = ns; req_addr = a; req_len = l;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_ctrl(input int base);
      for (int k = 0; k < 400 && cn == base; k++) @(negedge clk);
   endtask

   task automatic wait_resp(input int base);
      for (int k = 0; k < 400 && rsn == base; k++) @(negedge clk);
   endtask

   task automatic link(input bit d, input bit e);
      @(negedge clk); done_in = d; err_in = e;
      @(negedge clk); done_in = 1'b0; err_in = 1'b0;
   endtask

   task automatic t_reset;
      chk("R7", "busy after reset", busy, 0);
      chk("R7", "no fifo write after reset", fifo_wr_en, 0);
      chk("R11", "no response after reset", resp_valid, 0);
   endtask

   task automatic t_native_write;
      int wb = wn, cb = cn, sb = rsn;
      payload[0] = 8'h11; payload[1] = 8'h22; payload[2] = 8'h33;
      send(0, 1, 1, 1, 20'h5A3C1, 8'd3);
      wait_ctrl(cb);
      chk("R7", "busy while waiting", busy, 1);
      chk("R3", "native write word count", wn - wb, 7);
      chk("R1", "hdr0", wlog[wb % 1024], xw(8'h05, 1, 1, 0));
      chk("R1", "hdr1", wlog[(wb + 1) % 1024], xw(8'hA3, 0, 1, 0));
      chk("R1", "hdr2", wlog[(wb + 2) % 1024], xw(8'hC1, 0, 1, 0));
      chk("R2", "hdr3 len-1", wlog[(wb + 3) % 1024], xw(8'h02, 0, 1, 0));
      for (int k = 0; k < 3; k++)
         chk("R5", "payload word", wlog[(wb + 4 + k) % 1024], xw(payload[k], 0, 1, 0));
      chk("R6", "native ctrl ignores options", clog[cb % 64], 4'b0001);
      link(1, 0);
      wait_resp(sb);
      chk("R11", "write status", rs_stat, 0);
      chk("R11", "write count", rs_cnt, 3);
      @(negedge clk);
      chk("R7", "busy low after response", busy, 0);
   endtask

   task automatic t_i2c_ctrl(input bit na, input bit ns, input logic [3:0] exp);
      int cb = cn, sb = rsn;
      payload[0] = 8'h9C;
      send(0, 0, na, ns, 20'h00050, 8'd1);
      wait_ctrl(cb);
      chk("R6", "i2c ctrl word", clog[cb % 64], exp);
      link(1, 0);
      wait_resp(sb);
      chk("R11", "i2c write count", rs_cnt, 1);
   endtask

   task automatic t_read(input int bad_at, input int exp_cnt);
      int wb = wn, cb = cn, sb = rsn, rb = rn, pb = rptr;
      rsp_mem[pb % 16] = {8'h00, 8'h77, 8'hEE, 8'h00};
      for (int k = 0; k < 4; k++)
         rsp_mem[(pb + 1 + k) % 16] = {8'h00, (k == bad_at) ? 8'h5 : 8'(k), 8'hA0 + 8'(k), 8'h00};
      send(1, 0, 0, 0, 20'hF1234, 8'd4);
      wait_ctrl(cb);
      chk("R3", "read pushes header only", wn - wb, 4);
      chk("R1", "read hdr0 bit4", wlog[wb % 1024], xw(8'h1F, 1, 1, 0));
      chk("R2", "read hdr3", wlog[(wb + 3) % 1024], xw(8'h03, 0, 1, 0));
      chk("R6", "i2c read ctrl", clog[cb % 64], 4'b0011);
      link(1, 0);
      wait_resp(sb);
      chk("R9", "readout command word", wlog[(wb + 4) % 1024], xw(8'h00, 1, 0, 1));
      chk("R9", "pops incl discard", rptr - pb, exp_cnt + (exp_cnt < 4 ? 2 : 1));
      chk("R10", "reply writes", rn - rb, exp_cnt);
      for (int k = 0; k < exp_cnt; k++) begin
         chk("R10", "reply byte", rlog_b[(rb + k) % 256], 8'hA0 + k);
         chk("R10", "reply index", rlog_i[(rb + k) % 256], k);
      end
      chk("R10", "read count", rs_cnt, exp_cnt);
      chk("R11", "read status", rs_stat, 0);
   endtask

   task automatic t_refuse;
      int wb = wn, cb = cn, sb = rsn;
      for (int k = 0; k < 256; k++) payload[k] = 8'(k) ^ 8'h5A;
      send(0, 0, 0, 0, 20'h00050, 8'd125);
      wait_resp(sb);
      chk("R4", "refused status", rs_stat, 1);
      chk("R4", "refused count", rs_cnt, 0);
      chk("R4", "nothing pushed", wn - wb, 0);
      chk("R4", "no ctrl", cn - cb, 0);
      sb = rsn;
      send(0, 0, 0, 0, 20'h00050, 8'd124);
      wait_ctrl(cb);
      chk("R4", "124-byte write words", wn - wb, 128);
      chk("R3", "last payload", wlog[(wb + 127) % 1024], xw(payload[123], 0, 1, 0));
      link(1, 0);
      wait_resp(sb);
      chk("R11", "124 write count", rs_cnt, 124);
   endtask

   task automatic t_error(input bit with_done);
      int wb = wn, cb = cn, sb = rsn, rb = rn, pb = rptr;
      send(1, 1, 0, 0, 20'h00200, 8'd2);
      wait_ctrl(cb);
      link(with_done, 1);
      wait_resp(sb);
      chk("R8", "error status", rs_stat, 2);
      chk("R8", "error count", rs_cnt, 0);
      chk("R8", "no readout word", wn - wb, 4);
      chk("R8", "no pops", rptr - pb, 0);
      chk("R8", "no replies", rn - rb, 0);
   endtask

   task automatic t_busy_ignore;
      int wb = wn, cb = cn, sb = rsn;
      payload[0] = 8'h01; payload[1] = 8'h02;
      send(0, 1, 0, 0, 20'h00100, 8'd2);
      wait_ctrl(cb);
      send(1, 0, 0, 0, 20'hFFFFF, 8'd9);
      chk("R7", "no push from ignored request", wn - wb, 6);
      link(1, 0);
      wait_resp(sb);
      chk("R7", "count from first request", rs_cnt, 2);
      repeat (4) @(negedge clk);
      chk("R7", "ignored request left no trace", wn - wb, 6);
      chk("R7", "single ctrl", cn - cb, 1);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL R7 watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      for (int k = 0; k < 16; k++) rsp_mem[k] = '0;
      for (int k = 0; k < 256; k++) payload[k] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_native_write();
      t_i2c_ctrl(1, 0, 4'b0111);
      t_i2c_ctrl(1, 1, 4'b1111);
      t_read(-1, 4);
      t_read(2, 2);
      t_refuse();
      t_error(0);
      t_error(1);
      t_busy_ignore();
      finish_run();
   end
endmodule